// File: doc/BRIEF.md
# Elastic Postponing Refresh Scheduler

This block decides when one DRAM rank should be refreshed. It does not issue one refresh at every interval boundary. It counts interval boundaries and keeps a tally of refreshes that are owed. A memory controller's command arbiter consumes its requests.

While the tally is non-zero and the rank has been quiet for long enough, the block raises a low-priority request. The arbiter may serve that request during the lull. If eight refreshes pile up, the block raises an urgent request instead, and it holds that request until every owed refresh has been granted. This lets the arbiter clear the backlog back-to-back, ahead of normal traffic.

Each granted refresh marks the rank unavailable for a programmable completion time. A high-temperature flag halves the interval. The interval, the completion time and the required quiet time are programmable clock-cycle counts.

Top module: `elastic_refresh_sched`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `ref_req_opp`, `ref_req_urgent` and `rank_blocked` are 0, whatever the other inputs are. The owed tally and all timers restart from zero.
- R2: With `hot_flag` low, one refresh becomes owed every `cfg_interval` clock cycles. The first one becomes owed on the `cfg_interval`-th rising edge after reset is released.
- R3: With `hot_flag` high, the interval becomes `cfg_interval` shifted right by one bit. At 20, the first refresh is owed after 10 edges.
- R4: `ref_req_opp` is 1 exactly when all of these hold: at least one refresh is owed, `rank_idle` is 1 now, `rank_idle` was 1 at the preceding `cfg_idle_len` rising edges without a break, the rank is not blocked, and no urgent request is pending. A single low cycle of `rank_idle` restarts the quiet-time count.
- R5: The owed tally saturates at 8. Intervals that end while 8 are owed are lost. When the tally reaches 8, `ref_req_urgent` rises combinationally in that same cycle, unless the rank is blocked.
- R6: Once raised, the urgent condition persists until the tally returns to 0. While it persists, `ref_req_opp` stays 0 even when the rank is idle. From a full tally, exactly 8 grants are accepted.
- R7: A grant is accepted when `ref_grant` is 1, the rank is not blocked and at least one refresh is owed. An accepted grant lowers the tally by one. It also makes `rank_blocked` 1 for exactly `cfg_trfc` cycles, starting the cycle after the grant. With `cfg_trfc` of 0, the rank is not blocked at all.
- R8: A grant while `rank_blocked` is 1, or while nothing is owed, has no effect on the tally or on the blocking time.
- R9: While `rank_blocked` is 1, both request outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_interval | input | 16 | Refresh interval in clock cycles at normal temperature |
| cfg_trfc | input | 10 | Refresh completion time in clock cycles |
| cfg_idle_len | input | 8 | Consecutive idle cycles required before an opportunistic request |
| rank_idle | input | 1 | Rank has no pending traffic this cycle |
| hot_flag | input | 1 | High temperature: halves the interval |
| ref_grant | input | 1 | The arbiter issues a refresh this cycle |
| ref_req_opp | output | 1 | Low-priority refresh request during a lull |
| ref_req_urgent | output | 1 | Forced refresh request, takes priority over traffic |
| rank_blocked | output | 1 | Rank is busy finishing a refresh |

## Verification
The hardest state to reach is the saturated tally. It takes eight complete intervals with no idle period, followed by a drain in which every grant competes with completion blocking. The stimulus shortens the interval to four cycles and holds `rank_idle` low to fill the tally. It then keeps the tally full for several more intervals to test saturation. Before draining, it stretches the interval so that no new refresh becomes owed. With the grant held high and the rank reported idle, the bench counts the urgent request cycles. It expects exactly eight, and it expects no opportunistic request to appear during the drain.

// File: rtl/refsch_pkg.sv
package refsch_pkg;

    // Largest number of refreshes that may be postponed.
    localparam int unsigned OWED_MAX = 8;
    localparam int unsigned OWED_W   = $clog2(OWED_MAX + 1);

    typedef logic [OWED_W-1:0] owed_t;

    localparam owed_t OWED_FULL = owed_t'(OWED_MAX);
    localparam owed_t OWED_NONE = owed_t'(0);
    localparam owed_t OWED_ONE  = owed_t'(1);

    // Debt state carried between the tracker and the request logic.
    typedef struct packed {
        owed_t owed;
        logic  drain;
    } debt_state_t;

    // Which request the block presents in a cycle.
    typedef enum logic [1:0] {
        REQ_NONE   = 2'd0,
        REQ_OPP    = 2'd1,
        REQ_URGENT = 2'd2
    } req_kind_t;

    // Next tally given one interval end and one accepted grant.
    function automatic owed_t owed_step(owed_t cur, logic tick, logic take);
        owed_t nxt;
        nxt = cur;
        unique case ({tick, take})
            2'b10:   nxt = (cur == OWED_FULL) ? cur : cur + OWED_ONE;
            2'b01:   nxt = (cur == OWED_NONE) ? cur : cur - OWED_ONE;
            default: nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/refsch_interval_timer.sv
module refsch_interval_timer #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cfg_interval,
    input  logic             hot,
    output logic             tick
);
    localparam logic [CNT_W:0] STEP = (CNT_W + 1)'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic [CNT_W:0]   cnt_inc;

    // At high temperature the period is halved.
    always_comb begin
        limit   = hot ? (cfg_interval >> 1) : cfg_interval;
        cnt_inc = {1'b0, cnt_q} + STEP;
        tick    = (cnt_inc >= {1'b0, limit});
    end

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_inc[CNT_W-1:0];
    end
endmodule

// File: rtl/refsch_idle_filter.sv
module refsch_idle_filter #(
    parameter int unsigned IDLE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDLE_W-1:0] cfg_len,
    input  logic              rank_idle,
    output logic              lull
);
    logic [IDLE_W-1:0] run_q;
    logic              reached;

    assign reached = (run_q >= cfg_len);
    assign lull    = rank_idle && reached;

    // Counts consecutive idle edges, saturating at the programmed length.
    always_ff @(posedge clk) begin
        if (rst || !rank_idle) run_q <= '0;
        else if (!reached)     run_q <= run_q + IDLE_W'(1);
    end
endmodule

// File: rtl/refsch_debt_tracker.sv
module refsch_debt_tracker
    import refsch_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        take,
    output debt_state_t st
);
    debt_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{owed: OWED_NONE, drain: 1'b0};
        end else begin
            st_q.owed <= owed_step(st_q.owed, tick, take);
            // Drain mode starts at a full tally and ends once it is empty.
            if (st_q.owed == OWED_FULL)      st_q.drain <= 1'b1;
            else if (st_q.owed == OWED_NONE) st_q.drain <= 1'b0;
        end
    end

    assign st = st_q;
endmodule

// File: rtl/refsch_busy_timer.sv
module refsch_busy_timer #(
    parameter int unsigned TRFC_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [TRFC_W-1:0] cfg_trfc,
    output logic              busy
);
    logic [TRFC_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)              left_q <= '0;
        else if (start)       left_q <= cfg_trfc;
        else if (left_q != 0) left_q <= left_q - TRFC_W'(1);
    end

    assign busy = (left_q != '0);
endmodule

// File: rtl/elastic_refresh_sched.sv
module elastic_refresh_sched
    import refsch_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned TRFC_W = 10,
    parameter int unsigned IDLE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  cfg_interval,
    input  logic [TRFC_W-1:0] cfg_trfc,
    input  logic [IDLE_W-1:0] cfg_idle_len,
    input  logic              rank_idle,
    input  logic              hot_flag,
    input  logic              ref_grant,
    output logic              ref_req_opp,
    output logic              ref_req_urgent,
    output logic              rank_blocked
);
    logic        tick;
    logic        lull;
    logic        busy;
    logic        take;
    logic        urgent_raw;
    logic        owed_any;
    debt_state_t debt;
    req_kind_t   kind;
    owed_t       owed_cnt;

    refsch_interval_timer #(.CNT_W(CNT_W)) interval_i (
        .clk          (clk),
        .rst          (rst),
        .cfg_interval (cfg_interval),
        .hot          (hot_flag),
        .tick         (tick)
    );

    refsch_idle_filter #(.IDLE_W(IDLE_W)) idle_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_len   (cfg_idle_len),
        .rank_idle (rank_idle),
        .lull      (lull)
    );

    refsch_debt_tracker debt_i (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .take (take),
        .st   (debt)
    );

    refsch_busy_timer #(.TRFC_W(TRFC_W)) busy_i (
        .clk      (clk),
        .rst      (rst),
        .start    (take),
        .cfg_trfc (cfg_trfc),
        .busy     (busy)
    );

    assign owed_cnt   = debt.owed;
    assign owed_any   = (debt.owed != OWED_NONE);
    assign urgent_raw = (debt.drain && owed_any) || (debt.owed == OWED_FULL);
    assign take       = ref_grant && !busy && owed_any;

    always_comb begin
        kind = REQ_NONE;
        if (!busy) begin
            if (urgent_raw)            kind = REQ_URGENT;
            else if (owed_any && lull) kind = REQ_OPP;
        end
    end

    assign ref_req_opp    = (kind == REQ_OPP);
    assign ref_req_urgent = (kind == REQ_URGENT);
    assign rank_blocked   = busy;
endmodule

// File: rtl/refsch_checker.sv
module refsch_checker
    import refsch_pkg::*;
#(
    parameter int unsigned TRFC_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              ref_grant,
    input logic [TRFC_W-1:0] cfg_trfc,
    input logic              ref_req_opp,
    input logic              ref_req_urgent,
    input logic              rank_blocked,
    input owed_t             owed_cnt
);
    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(ref_req_opp && ref_req_urgent)); // R6

    AST_QUIET_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        rank_blocked |-> (!ref_req_opp && !ref_req_urgent)); // R9

    AST_GRANT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (ref_grant && (ref_req_opp || ref_req_urgent) && (cfg_trfc != '0)) |=> rank_blocked); // R7

    AST_URGENT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (ref_req_urgent && !ref_grant) |=> ref_req_urgent); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        owed_cnt <= OWED_FULL); // R5

    AST_FULL_IS_URGENT: assert property (@(posedge clk) disable iff (rst)
        ((owed_cnt == OWED_FULL) && !rank_blocked) |-> ref_req_urgent); // R5

    AST_BLOCK_NEEDS_GRANT: assert property (@(posedge clk) disable iff (rst)
        $rose(rank_blocked) |-> $past(ref_grant)); // R8
endmodule

bind elastic_refresh_sched refsch_checker #(.TRFC_W(TRFC_W)) chk_i (
    .clk            (clk),
    .rst            (rst),
    .ref_grant      (ref_grant),
    .cfg_trfc       (cfg_trfc),
    .ref_req_opp    (ref_req_opp),
    .ref_req_urgent (ref_req_urgent),
    .rank_blocked   (rank_blocked),
    .owed_cnt       (owed_cnt)
);

// File: tb/elastic_refresh_sched_tb.sv
module elastic_refresh_sched_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cfg_interval = 16'd10;
    logic [9:0]  cfg_trfc = 10'd3;
    logic [7:0]  cfg_idle_len = 8'd2;
    logic        rank_idle = 1'b0;
    logic        hot_flag = 1'b0;
    logic        ref_grant = 1'b0;
    logic        ref_req_opp, ref_req_urgent, rank_blocked;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk; // 50 MHz

    elastic_refresh_sched dut_i (
        .clk(clk), .rst(rst), .cfg_interval(cfg_interval), .cfg_trfc(cfg_trfc),
        .cfg_idle_len(cfg_idle_len), .rank_idle(rank_idle), .hot_flag(hot_flag),
        .ref_grant(ref_grant), .ref_req_opp(ref_req_opp),
        .ref_req_urgent(ref_req_urgent), .rank_blocked(rank_blocked)
    );

    typedef struct packed {
        logic       hot;
        logic       idle;
        logic       grant;
        logic [7:0] n;
        logic [2:0] exp; // {opp, urgent, blocked}
    } vec_t;

    // Interval 10, completion 3, quiet time 2; counts are edges per entry.
    localparam vec_t VECS [17] = '{
        '{1'b0, 1'b0, 1'b0, 8'd9,  3'b000}, // R2 nothing owed before 10 edges
        '{1'b0, 1'b1, 1'b0, 8'd1,  3'b000}, // R4 owed, idle only 1 edge
        '{1'b0, 1'b1, 1'b0, 8'd1,  3'b100}, // R4 idle 2 edges
        '{1'b0, 1'b1, 1'b1, 8'd1,  3'b001}, // R7 grant accepted
        '{1'b0, 1'b1, 1'b1, 8'd1,  3'b001}, // R8 grant while blocked
        '{1'b0, 1'b1, 1'b0, 8'd1,  3'b001}, // R7 third blocked cycle
        '{1'b0, 1'b1, 1'b0, 8'd1,  3'b000}, // R7 unblocked, nothing owed
        '{1'b0, 1'b1, 1'b0, 8'd5,  3'b100}, // R2 second interval ends
        '{1'b0, 1'b0, 1'b0, 8'd10, 3'b000}, // R4 busy rank, two owed
        '{1'b0, 1'b1, 1'b0, 8'd2,  3'b100}, // R4 lull
        '{1'b0, 1'b1, 1'b1, 8'd1,  3'b001}, // R7 one left
        '{1'b0, 1'b1, 1'b1, 8'd3,  3'b100}, // R8 blocked grants ignored, one still owed
        '{1'b0, 1'b0, 1'b0, 8'd1,  3'b000}, // R4 idle broken
        '{1'b0, 1'b1, 1'b0, 8'd1,  3'b000}, // R4 restart count
        '{1'b0, 1'b0, 1'b0, 8'd1,  3'b000}, // R4 broken again
        '{1'b0, 1'b1, 1'b0, 8'd1,  3'b000}, // R4 one edge
        '{1'b0, 1'b1, 1'b0, 8'd1,  3'b100}  // R4 two edges
    };

    function automatic logic [2:0] outs();
        return {ref_req_opp, ref_req_urgent, rank_blocked};
    endfunction

    task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: opp/urg/blk actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; rank_idle = 1'b1; ref_grant = 1'b1; hot_flag = 1'b0;
        run(3);
        chk("R1 during reset", outs(), 3'b000);
        rank_idle = 1'b0; ref_grant = 1'b0;
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        int accepts;
        int opp_seen;

        // Table walk
        cfg_interval = 16'd10; cfg_trfc = 10'd3; cfg_idle_len = 8'd2;
        do_reset();
        for (int v = 0; v < 17; v++) begin
            hot_flag = VECS[v].hot; rank_idle = VECS[v].idle; ref_grant = VECS[v].grant;
            run(int'(VECS[v].n));
            chk($sformatf("R2/R4/R7/R8 vector %0d", v), outs(), VECS[v].exp);
        end

        // R3: halved interval, zero quiet time, zero completion time
        cfg_interval = 16'd20; cfg_trfc = 10'd0; cfg_idle_len = 8'd0;
        do_reset();
        hot_flag = 1'b1; rank_idle = 1'b1;
        run(9);
        chk("R3 before half interval", outs(), 3'b000);
        run(1);
        chk("R3 at half interval", outs(), 3'b100);
        ref_grant = 1'b1;
        run(1);
        chk("R7 zero completion time", outs(), 3'b000);
        ref_grant = 1'b0;
        run(10);
        chk("R3 next half interval", outs(), 3'b100);
        rst = 1'b1;
        run(1);
        chk("R1 reset mid-run", outs(), 3'b000);

        // R5 / R6: saturation and forced drain
        cfg_interval = 16'd4; cfg_trfc = 10'd2; cfg_idle_len = 8'd0;
        do_reset();
        run(31);
        chk("R5 seven owed", outs(), 3'b000);
        run(1);
        chk("R5 eighth owed raises urgent", outs(), 3'b010);
        run(8);
        chk("R5 saturated tally stays urgent", outs(), 3'b010);
        cfg_interval = 16'hFFFF;
        rank_idle = 1'b1;
        accepts = 0;
        opp_seen = 0;
        for (int k = 0; k < 40; k++) begin
            ref_grant = 1'b1;
            if (ref_req_urgent && !rank_blocked) accepts++;
            if (ref_req_opp) opp_seen++;
            run(1);
        end
        ref_grant = 1'b0;
        chk_int("R6 grants accepted from full tally", accepts, 8);
        chk_int("R6 no opportunistic request while urgent", opp_seen, 0);
        run(1);
        chk("R6 drained", outs(), 3'b000);

        finish_run();
    end
endmodule